// File: doc/BRIEF.md
# Per-Line Transmit Clock Source Selector

This block picks the transmit clock for each of several serial lines. Every line can take its clock from one of four places: the line's own receive clock looped back, a nominal E1/T1 rate made by a shared synthesizer, a per-line clock rebuilt from received timing-residual values, or a clock supplied from outside the chip. Clocks are carried as single-cycle enable pulses in the system clock domain. The output for each line is a registered tick and a direction flag. The direction flag says whether the line's clock pin drives or listens.

Software writes a two-bit source code for one line at a time into a staged register. Nothing changes at the outputs until a one-cycle commit strobe copies every staged code into the active set at once. From hardware reset until the first commit, a single strap-style enable input decides for all lines together. When it is high, every line loops its receive clock and drives its pin. When it is low, every pin is an input and the external clock is passed through. While the soft-reset input is held, every line that is on a synthesized source outputs a constant 0.

Top module: `txclk_source_sel`

## Requirements
- R1: While hardware reset is asserted, and in the first cycle after it, every tx_tick bit is 0.
- R2: Before the first commit, with clk_out_en low, every line's tx_tick equals its ext_tick from the previous cycle and tx_drive is 0 on every line.
- R3: Before the first commit, with clk_out_en high, every line's tx_tick equals its rx_tick from the previous cycle and tx_drive is 1 on every line.
- R4: A cfg_wr with no cfg_commit changes neither tx_tick nor tx_drive on any line.
- R5: A cfg_commit pulse copies the staged codes of all lines into the active set at the same clock edge. tx_drive follows the new codes right after that edge, and tx_tick follows them one cycle later.
- R6: Code 2'b01 makes the line follow its own rx_tick and drive its pin.
- R7: Code 2'b10 makes the line follow the shared nom_tick and drive its pin.
- R8: Code 2'b11 makes the line follow its own res_tick and drive its pin.
- R9: Code 2'b00 makes the line follow its own ext_tick, and tx_drive is 0, so the pin is an input.
- R10: After the first commit, clk_out_en has no effect on any output.
- R11: While soft_rst is high, a line whose effective code is 2'b10 or 2'b11 outputs tx_tick 0. Lines on 2'b00 or 2'b01 are unaffected, and tx_drive is unchanged.
- R12: A cfg_wr in the same cycle as cfg_commit lands only in the staged register. It takes effect at the next commit.
- R13: Staged codes reset to 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| clk_out_en | input | 1 | Global default selector used until the first commit |
| soft_rst | input | 1 | Soft reset; silences synthesized sources |
| cfg_wr | input | 1 | Write strobe for one staged code |
| cfg_line | input | LW | Line index for cfg_wr |
| cfg_code | input | 2 | Source code to stage |
| cfg_commit | input | 1 | Single-cycle strobe that applies all staged codes |
| rx_tick | input | N | Per-line looped receive clock enables |
| nom_tick | input | 1 | Shared nominal E1/T1 synthesized clock enable |
| res_tick | input | N | Per-line residual-based synthesized clock enables |
| ext_tick | input | N | Per-line external clock enables |
| tx_tick | output | N | Per-line registered transmit clock enable |
| tx_drive | output | N | 1 when the line's clock pin is an output |

## Verification
The bench targets the window before the first commit under both levels of the global enable. A design that ignored the strap, or that treated it as a per-line setting, would show the wrong source or the wrong direction there. It also flips the strap after the first commit, which catches designs that keep honouring it. The bench places a stage write in the same cycle as a commit to catch designs that leak fresh data into the active set. It stages codes without committing to catch designs that apply them early. Finally, it raises soft reset with all four codes active at once. A design that silenced the wrong lines, or that dropped the drive flag, shows up against the per-line expectations.

// File: rtl/txclk_sel_pkg.sv
package txclk_sel_pkg;

    typedef enum logic [1:0] {
        SRC_EXT  = 2'b00,
        SRC_LOOP = 2'b01,
        SRC_NOM  = 2'b10,
        SRC_RES  = 2'b11
    } src_e;

    typedef struct packed {
        logic loop_t;
        logic nom_t;
        logic res_t;
        logic ext_t;
    } tick_set_t;

    function automatic logic src_synth(src_e s);
        return (s == SRC_NOM) || (s == SRC_RES);
    endfunction

    function automatic logic src_drives(src_e s);
        return s != SRC_EXT;
    endfunction

    function automatic src_e strap_src(logic oe);
        return oe ? SRC_LOOP : SRC_EXT;
    endfunction

endpackage

// File: rtl/txclk_cfg_bank.sv
module txclk_cfg_bank
    import txclk_sel_pkg::*;
#(
    parameter int N  = 4,
    parameter int LW = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [LW-1:0]     line,
    input  src_e              code,
    input  logic              commit,
    output src_e [N-1:0]      act,
    output logic              done
);

    src_e [N-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                stg[i] <= SRC_EXT;
                act[i] <= SRC_EXT;
            end
            done <= 1'b0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (wr && (line == LW'(i))) begin
                    stg[i] <= code;
                end
            end
            if (commit) begin
                act  <= stg;
                done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/txclk_line_mux.sv
module txclk_line_mux
    import txclk_sel_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  src_e      src,
    input  logic      soft_rst,
    input  tick_set_t ticks,
    output logic      tick_q,
    output logic      drive
);

    logic sel;

    always_comb begin
        unique case (src)
            SRC_EXT:  sel = ticks.ext_t;
            SRC_LOOP: sel = ticks.loop_t;
            SRC_NOM:  sel = ticks.nom_t;
            SRC_RES:  sel = ticks.res_t;
            default:  sel = 1'b0;
        endcase
        if (soft_rst && src_synth(src)) begin
            sel = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= sel;
        end
    end

    assign drive = src_drives(src);

endmodule

// File: rtl/txclk_source_sel.sv
module txclk_source_sel
    import txclk_sel_pkg::*;
#(
    parameter int N  = 4,
    parameter int LW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clk_out_en,
    input  logic          soft_rst,
    input  logic          cfg_wr,
    input  logic [LW-1:0] cfg_line,
    input  logic [1:0]    cfg_code,
    input  logic          cfg_commit,
    input  logic [N-1:0]  rx_tick,
    input  logic          nom_tick,
    input  logic [N-1:0]  res_tick,
    input  logic [N-1:0]  ext_tick,
    output logic [N-1:0]  tx_tick,
    output logic [N-1:0]  tx_drive
);

    src_e [N-1:0] act;
    src_e [N-1:0] eff;
    logic         done;

    txclk_cfg_bank #(.N(N), .LW(LW)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr     (cfg_wr),
        .line   (cfg_line),
        .code   (src_e'(cfg_code)),
        .commit (cfg_commit),
        .act    (act),
        .done   (done)
    );

    for (genvar g = 0; g < N; g++) begin : g_line
        tick_set_t ts;

        assign eff[g] = done ? act[g] : strap_src(clk_out_en);
        assign ts     = '{loop_t: rx_tick[g], nom_t: nom_tick,
                          res_t: res_tick[g], ext_t: ext_tick[g]};

        txclk_line_mux u_mux (
            .clk      (clk),
            .rst      (rst),
            .src      (eff[g]),
            .soft_rst (soft_rst),
            .ticks    (ts),
            .tick_q   (tx_tick[g]),
            .drive    (tx_drive[g])
        );
    end

endmodule

// File: rtl/txclk_source_sel_chk.sv
module txclk_source_sel_chk
    import txclk_sel_pkg::*;
#(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         clk_out_en,
    input logic         soft_rst,
    input logic         cfg_commit,
    input src_e [N-1:0] act,
    input src_e [N-1:0] eff,
    input logic         done,
    input logic [N-1:0] tx_tick,
    input logic [N-1:0] tx_drive
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> tx_tick == '0); // R1

    AST_STRAP_DIRECTION: assert property (@(posedge clk) disable iff (rst)
        !done |-> tx_drive == {N{clk_out_en}}); // R2

    AST_COMMIT_APPLIES: assert property (@(posedge clk) disable iff (rst)
        cfg_commit |=> done); // R5

    AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !cfg_commit |=> $stable(act)); // R4

    AST_STRAP_RETIRED: assert property (@(posedge clk) disable iff (rst)
        done |=> done); // R10

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_SOFT_SILENCE: assert property (@(posedge clk) disable iff (rst)
            (soft_rst && src_synth(eff[g])) |=> !tx_tick[g]); // R11

        AST_EXT_IS_INPUT: assert property (@(posedge clk) disable iff (rst)
            (done && act[g] == SRC_EXT) |-> !tx_drive[g]); // R9
    end

endmodule

bind txclk_source_sel txclk_source_sel_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clk_out_en (clk_out_en),
    .soft_rst   (soft_rst),
    .cfg_commit (cfg_commit),
    .act        (act),
    .eff        (eff),
    .done       (done),
    .tx_tick    (tx_tick),
    .tx_drive   (tx_drive)
);

// File: tb/tb_txclk_source_sel.sv
module tb_txclk_source_sel;

    localparam int N      = 4;
    localparam int LW     = 2;
    localparam int PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic          clk_out_en;
    logic          soft_rst;
    logic          cfg_wr;
    logic [LW-1:0] cfg_line;
    logic [1:0]    cfg_code;
    logic          cfg_commit;
    logic [N-1:0]  rx_tick;
    logic          nom_tick;
    logic [N-1:0]  res_tick;
    logic [N-1:0]  ext_tick;
    logic [N-1:0]  tx_tick;
    logic [N-1:0]  tx_drive;

    int checks = 0;
    int errors = 0;

    logic [1:0] m_stg [N];
    logic [1:0] m_act [N];
    logic       m_done;

    always #(PERIOD/2) clk = ~clk;

    txclk_source_sel #(.N(N), .LW(LW)) dut (
        .clk(clk), .rst(rst), .clk_out_en(clk_out_en), .soft_rst(soft_rst),
        .cfg_wr(cfg_wr), .cfg_line(cfg_line), .cfg_code(cfg_code),
        .cfg_commit(cfg_commit), .rx_tick(rx_tick), .nom_tick(nom_tick),
        .res_tick(res_tick), .ext_tick(ext_tick), .tx_tick(tx_tick),
        .tx_drive(tx_drive)
    );

    task automatic check(string req, string what, logic [N-1:0] act_v, logic [N-1:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act_v, exp_v);
        end
    endtask

    function automatic logic [1:0] src_of(int i);
        if (m_done) return m_act[i];
        return clk_out_en ? 2'b01 : 2'b00;
    endfunction

    // apply one input pattern, step one edge, compare against the model
    task automatic check_pat(string req, logic [N-1:0] rx, logic nom,
                             logic [N-1:0] res, logic [N-1:0] ext);
        logic [N-1:0] e_tick;
        logic [N-1:0] e_drv;
        @(negedge clk);
        rx_tick = rx; nom_tick = nom; res_tick = res; ext_tick = ext;
        for (int i = 0; i < N; i++) begin
            logic [1:0] s;
            s = src_of(i);
            e_drv[i] = (s != 2'b00);
            case (s)
                2'b00:   e_tick[i] = ext[i];
                2'b01:   e_tick[i] = rx[i];
                2'b10:   e_tick[i] = nom;
                default: e_tick[i] = res[i];
            endcase
            if (soft_rst && s[1]) e_tick[i] = 1'b0;
        end
        @(posedge clk); #1;
        check(req, "tx_tick", tx_tick, e_tick);
        check(req, "tx_drive", tx_drive, e_drv);
        @(negedge clk);
        rx_tick = '0; nom_tick = 1'b0; res_tick = '0; ext_tick = '0;
    endtask

    task automatic run_pats(string req);
        check_pat(req, 4'b1010, 1'b1, 4'b0110, 4'b0101);
        check_pat(req, 4'b0101, 1'b0, 4'b1001, 4'b1010);
        check_pat(req, 4'b1111, 1'b1, 4'b0000, 4'b0011);
        check_pat(req, 4'b0000, 1'b0, 4'b1111, 4'b1100);
    endtask

    task automatic stage(int line, logic [1:0] code);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_line = LW'(line); cfg_code = code;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        m_stg[line] = code;
    endtask

    task automatic commit();
        @(negedge clk);
        cfg_commit = 1'b1;
        @(posedge clk); #1;
        cfg_commit = 1'b0;
        for (int i = 0; i < N; i++) m_act[i] = m_stg[i];
        m_done = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; clk_out_en = 1'b0;
        rx_tick = '1; nom_tick = 1'b1; res_tick = '1; ext_tick = '1;
        repeat (2) @(posedge clk);
        #1;
        check("R1", "tx_tick in reset", tx_tick, '0);
        @(negedge clk);
        rst = 1'b0;
        rx_tick = '0; nom_tick = 1'b0; res_tick = '0; ext_tick = '0;
        for (int i = 0; i < N; i++) begin m_stg[i] = 2'b00; m_act[i] = 2'b00; end
        m_done = 1'b0;
        @(posedge clk); #1;
        check("R1", "tx_tick after reset", tx_tick, '0);
    endtask

    task automatic t_strap_low();
        clk_out_en = 1'b0;
        run_pats("R2");
    endtask

    task automatic t_strap_high();
        clk_out_en = 1'b1;
        run_pats("R3");
    endtask

    task automatic t_stage_only();
        clk_out_en = 1'b1;
        stage(0, 2'b00);
        stage(1, 2'b01);
        stage(2, 2'b10);
        stage(3, 2'b11);
        run_pats("R4");
    endtask

    task automatic t_reset_staged_zero();
        // commit with nothing staged since reset: every line must go external
        commit();
        check("R13", "tx_drive with reset staged codes", tx_drive, '0);
        run_pats("R13");
    endtask

    task automatic t_commit_modes();
        stage(0, 2'b00);
        stage(1, 2'b01);
        stage(2, 2'b10);
        stage(3, 2'b11);
        commit();
        check("R5", "tx_drive right after commit", tx_drive, 4'b1110);
        run_pats("R5/R6/R7/R8/R9");
        // rotate codes to exercise every code on other lines
        stage(0, 2'b11);
        stage(1, 2'b10);
        stage(2, 2'b01);
        stage(3, 2'b00);
        commit();
        check("R9", "tx_drive after rotation", tx_drive, 4'b0111);
        run_pats("R6/R7/R8/R9");
    endtask

    task automatic t_strap_ignored();
        clk_out_en = 1'b0;
        run_pats("R10");
        clk_out_en = 1'b1;
        run_pats("R10");
    endtask

    task automatic t_soft_reset();
        stage(0, 2'b00);
        stage(1, 2'b01);
        stage(2, 2'b10);
        stage(3, 2'b11);
        commit();
        soft_rst = 1'b1;
        run_pats("R11");
        soft_rst = 1'b0;
        run_pats("R11");
    endtask

    task automatic t_same_cycle();
        logic [1:0] prev0;
        prev0 = m_stg[0];
        @(negedge clk);
        cfg_wr = 1'b1; cfg_line = 2'd0; cfg_code = 2'b10; cfg_commit = 1'b1;
        @(posedge clk); #1;
        cfg_wr = 1'b0; cfg_commit = 1'b0;
        for (int i = 0; i < N; i++) m_act[i] = m_stg[i];
        m_act[0] = prev0;
        m_stg[0] = 2'b10;
        m_done = 1'b1;
        run_pats("R12");
        commit();
        run_pats("R12");
    endtask

    initial begin
        rst = 1'b1; clk_out_en = 1'b0; soft_rst = 1'b0;
        cfg_wr = 1'b0; cfg_line = '0; cfg_code = '0; cfg_commit = 1'b0;
        rx_tick = '0; nom_tick = 1'b0; res_tick = '0; ext_tick = '0;
        t_reset();
        t_strap_low();
        t_strap_high();
        t_stage_only();
        t_reset();
        t_reset_staged_zero();
        t_reset();
        t_commit_modes();
        t_strap_ignored();
        t_soft_reset();
        t_same_cycle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 50000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule